// File: doc/BRIEF.md
# Bus Hand-Over Controller

This block lets a processor give its multiplexed address/data and control buses to an external bus master and take them back again. An external master asks for the bus on an active-low request pin, `busReqN`. That pin is not timed to the processor clock. The block passes it through a synchronizer. It looks at the synchronized request only in the first clock of a machine cycle. If a request is seen there, the block waits for that machine cycle to finish and then hands the bus over. At hand-over it drives its active-low acknowledge pin low and turns off every bus output driver on the same clock edge.

While the bus is away, the block holds the core with a stall output, so the core starts no new machine cycle. When the external master lets go of the request, the block synchronizes the release edge. One clock after that edge it raises the acknowledge pin and turns the bus drivers back on, both in the same cycle. The core uses two pulse inputs to tell the block where machine cycles begin and end.

Top module: `bus_handover`

## Requirements
- R1: During and right after reset, and also when reset is applied in the middle of a hand-over: `busAckN` is 1, every bit of `busOe` is 1 (drivers on) and `coreStall` is 0.
- R2: `busReqN` passes through SYNC_STAGES flops (default 2) before the block uses it. A low level is recognised at a cycle start only after SYNC_STAGES rising edges. A cycle start in the first clock after the pin falls does not take the request.
- R3: The request is sampled only in clocks where `cycleStart` is 1. A request that rises and falls again between two cycle starts has no effect.
- R4: After a request is sampled, `busAckN` goes low on the rising edge that ends the clock in which `cycleEnd` is 1. This holds also when `cycleStart` and `cycleEnd` are high in the same clock.
- R5: `busAckN` low and all `busOe` bits 0 always change together, on the same edge.
- R6: `coreStall` goes to 1 on the edge that samples the request. It stays 1 for as long as `busAckN` is low.
- R7: After `busReqN` returns high, `busAckN` goes high exactly SYNC_STAGES+1 rising edges later. That is one clock after the synchronized release edge.
- R8: `busOe` returns to all ones, and `coreStall` returns to 0, on the same edge as `busAckN` rises. Never earlier.
- R9: Once a request is sampled, the grant still happens at the next cycle end even if `busReqN` has gone high since. It is then released one clock later.
- R10: While the bus is handed over, `cycleStart` and `cycleEnd` have no effect. `busAckN` stays low while the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReqN | input | 1 | Bus request from the external master. Active low and not timed to `clk` |
| cycleStart | input | 1 | High in the first clock of a machine cycle |
| cycleEnd | input | 1 | High in the last clock of a machine cycle |
| busAckN | output | 1 | Active-low bus acknowledge |
| busOe | output | OE_GROUPS | Bus driver enables, one per driver group; 1 = drive |
| coreStall | output | 1 | Holds the core from starting a new machine cycle |

## Verification
The bench goes after several timing corners:
- A request that arrives too soon after the pin falls, and one that comes and goes between cycle starts. A design that sampled on every clock, or that used the raw pin, would stall or grant in these cases.
- A single-clock machine cycle. A design that needed a registered pending state before it could grant would never grant here, and would deadlock behind its own stall.
- A release that happens before the granted cycle ends. This must still grant and then release at once.
- The release delay itself. A design that re-enabled the drivers or raised acknowledge one clock early or late would put two drivers on the bus or waste bus time, and the bench would see it.

// File: rtl/busack_pkg.sv
package busack_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PEND   = 2'd1,
    ST_HANDED = 2'd2
  } hoState_t;

  typedef struct packed {
    logic sampleReq;
    logic grantBus;
    logic releaseBus;
  } hoStrobe_t;

endpackage

// File: rtl/busack_sync.sv
module busack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReqN,
  output logic reqSync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= ~busReqN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign reqSync = chain[LAST];
endmodule

// File: rtl/busack_ctrl.sv
module busack_ctrl
  import busack_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqSync,
  input  logic      cycleStart,
  input  logic      cycleEnd,
  output hoStrobe_t strobe
);
  hoState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    unique case (state)
      ST_RUN: begin
        if (cycleStart && reqSync) begin
          strobe.sampleReq = 1'b1;
          if (cycleEnd) begin
            strobe.grantBus = 1'b1;
            stateNext       = ST_HANDED;
          end else begin
            stateNext       = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (cycleEnd) begin
          strobe.grantBus = 1'b1;
          stateNext       = ST_HANDED;
        end
      end
      ST_HANDED: begin
        if (!reqSync) begin
          strobe.releaseBus = 1'b1;
          stateNext         = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/busack_dp.sv
module busack_dp
  import busack_pkg::*;
#(
  parameter int OE_GROUPS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hoStrobe_t            strobe,
  output logic                 busAckN,
  output logic [OE_GROUPS-1:0] busOe,
  output logic                 coreStall
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  busAckN <= 1'b1;
    else if (strobe.grantBus)   busAckN <= 1'b0;
    else if (strobe.releaseBus) busAckN <= 1'b1;
  end

  generate
    for (genvar g = 0; g < OE_GROUPS; g++) begin : g_oe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  busOe[g] <= 1'b1;
        else if (strobe.grantBus)   busOe[g] <= 1'b0;
        else if (strobe.releaseBus) busOe[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  coreStall <= 1'b0;
    else if (strobe.sampleReq)  coreStall <= 1'b1;
    else if (strobe.releaseBus) coreStall <= 1'b0;
  end
endmodule

// File: rtl/bus_handover.sv
module bus_handover
  import busack_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OE_GROUPS   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReqN,
  input  logic                 cycleStart,
  input  logic                 cycleEnd,
  output logic                 busAckN,
  output logic [OE_GROUPS-1:0] busOe,
  output logic                 coreStall
);
  logic      reqSync;
  hoStrobe_t strobe;

  busack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .busReqN (busReqN),
    .reqSync (reqSync)
  );

  busack_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqSync    (reqSync),
    .cycleStart (cycleStart),
    .cycleEnd   (cycleEnd),
    .strobe     (strobe)
  );

  busack_dp #(.OE_GROUPS(OE_GROUPS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAckN   (busAckN),
    .busOe     (busOe),
    .coreStall (coreStall)
  );
endmodule

// File: rtl/bus_handover_checker.sv
module bus_handover_checker #(
  parameter int OE_GROUPS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cycleStart,
  input logic                 cycleEnd,
  input logic                 reqSync,
  input logic                 busAckN,
  input logic [OE_GROUPS-1:0] busOe,
  input logic                 coreStall
);
  // R2 / R3: stall only starts from a sampled, synchronized request at a cycle start
  a_r3_sample_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreStall) |-> ($past(cycleStart) && $past(reqSync)));

  // R4: hand-over happens only at a cycle end
  a_r4_grant_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckN) |-> $past(cycleEnd));

  // R5: acknowledge and driver enables agree
  a_r5_ack_off_drivers: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> (busOe == '0));
  a_r5_ack_on_drivers: assert property (@(posedge clk) disable iff (!rstN)
    busAckN |-> (&busOe));

  // R6: core held while the bus is away
  a_r6_stall_held: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> coreStall);

  // R7: release one clock after the synchronized release
  a_r7_release_next: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && !reqSync) |=> busAckN);

  // R8: stall drops with acknowledge
  a_r8_stall_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAckN) |-> !coreStall);

  // R10: hand-over holds while the request is held
  a_r10_hold_granted: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && reqSync) |=> !busAckN);
endmodule

bind bus_handover bus_handover_checker #(.OE_GROUPS(OE_GROUPS)) u_chk (.*);

// File: tb/bus_handover_bench.sv
module bus_handover_bench;
  localparam int OEG = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busReqN = 1'b1;
  logic           cycleStart = 1'b0;
  logic           cycleEnd = 1'b0;
  logic           busAckN;
  logic [OEG-1:0] busOe;
  logic           coreStall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_handover #(.SYNC_STAGES(2), .OE_GROUPS(OEG)) u_bus_handover (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .cycleStart(cycleStart),
    .cycleEnd(cycleEnd), .busAckN(busAckN), .busOe(busOe), .coreStall(coreStall)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input int ack, input int oe, input int stall);
    chk({req, " busAckN"}, busAckN, ack);
    chk({req, " busOe"}, busOe, oe);
    chk({req, " coreStall"}, coreStall, stall);
  endtask

  // release from granted state, R7 and R8 timing
  task automatic releaseCheck();
    busReqN = 1'b1;
    step();
    chk("R7 edge1", busAckN, 0);
    step();
    chk("R7 edge2", busAckN, 0);
    step();
    chkOut("R7 R8 edge3", 1, 3, 0);
  endtask

  task automatic t_reset();
    chkOut("R1 reset", 1, 3, 0);
    rstN = 1'b1;
    step();
    chkOut("R1 after reset", 1, 3, 0);
  endtask

  task automatic t_syncDelay();
    busReqN = 1'b0;
    cycleStart = 1'b1;
    step();
    cycleStart = 1'b0;
    busReqN = 1'b1;
    chk("R2 early start ignored", coreStall, 0);
    repeat (4) step();
    chkOut("R2 idle", 1, 3, 0);
  endtask

  task automatic t_grantRelease();
    busReqN = 1'b0;
    step(); step();
    cycleStart = 1'b1;
    step();
    cycleStart = 1'b0;
    chkOut("R6 sampled", 1, 3, 1);
    step();
    chk("R4 waits for end", busAckN, 1);
    cycleEnd = 1'b1;
    step();
    cycleEnd = 1'b0;
    chkOut("R4 R5 granted", 0, 0, 1);
    releaseCheck();
  endtask

  task automatic t_betweenStarts();
    busReqN = 1'b0;
    repeat (4) step();
    busReqN = 1'b1;
    repeat (4) step();
    cycleStart = 1'b1; cycleEnd = 1'b1;
    step();
    cycleStart = 1'b0; cycleEnd = 1'b0;
    chkOut("R3 pulse ignored", 1, 3, 0);
  endtask

  task automatic t_singleClock();
    busReqN = 1'b0;
    step(); step();
    cycleStart = 1'b1; cycleEnd = 1'b1;
    step();
    cycleStart = 1'b0; cycleEnd = 1'b0;
    chkOut("R4 single clock grant", 0, 0, 1);
    releaseCheck();
  endtask

  task automatic t_earlyRelease();
    busReqN = 1'b0;
    step(); step();
    cycleStart = 1'b1;
    step();
    cycleStart = 1'b0;
    busReqN = 1'b1;
    repeat (3) step();
    chkOut("R9 still pending", 1, 3, 1);
    cycleEnd = 1'b1;
    step();
    cycleEnd = 1'b0;
    chkOut("R9 granted anyway", 0, 0, 1);
    step();
    chkOut("R9 released next", 1, 3, 0);
  endtask

  task automatic t_ignoreCycles();
    busReqN = 1'b0;
    step(); step();
    cycleStart = 1'b1; cycleEnd = 1'b1;
    step();
    repeat (3) step();
    cycleStart = 1'b0; cycleEnd = 1'b0;
    chkOut("R10 held", 0, 0, 1);
    releaseCheck();
  endtask

  task automatic t_resetMid();
    busReqN = 1'b0;
    step(); step();
    cycleStart = 1'b1; cycleEnd = 1'b1;
    step();
    cycleStart = 1'b0; cycleEnd = 1'b0;
    chk("R1 pre-reset granted", busAckN, 0);
    busReqN = 1'b1;
    rstN = 1'b0;
    step();
    chkOut("R1 reset mid grant", 1, 3, 0);
    rstN = 1'b1;
    repeat (3) step();
    chkOut("R1 after mid reset", 1, 3, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_syncDelay();
    t_grantRelease();
    t_betweenStarts();
    t_singleClock();
    t_earlyRelease();
    t_ignoreCycles();
    t_resetMid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule